// File: doc/BRIEF.md
# External Bus Release Controller

This block arbitrates ownership of the external memory bus between the CPU bus sequencer and an outside bus master. The outside master asks for the bus by pulling an active-low request line. The block hands the bus over with an active-low acknowledge. While the outside master owns the bus, the block turns off the CPU's address, data and strobe drivers and stalls the sequencer.

The request is sampled only on clock edges that the sequencer marks as sample points. It is accepted only after it has been seen low on a configurable number of consecutive sample points; the default is two. Once the request is accepted, the block lets any access already in flight run to its end. It then drives every strobe to its inactive high level for one state. After that it turns the drivers off and asserts acknowledge on the same edge.

While the bus is released, the request is checked on every edge. When the request goes high, acknowledge is withdrawn first. The CPU drivers come back one state later, and the stall is lifted at the same time.

Top module: `bus_release_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `back_no` is 1, `hold_cpu_o` is 0, `addr_oe_o` and `strb_oe_o` are 1, and `strb_no` equals `strb_ni`.
- R2: While the CPU owns the bus, `breq_ni` is looked at only on rising edges where `sample_i` is 1. A low level present only on edges where `sample_i` is 0 has no effect.
- R3: A request is accepted only when `breq_ni` is 0 at NUM_SAMPLES consecutive sample edges. A high value at any sample edge restarts the count, so a request seen low at just one sample edge is rejected.
- R4: After acceptance, release waits for the first edge at which `cpu_busy_i` is 0 or `cpu_done_i` is 1. The edge after that one drops `back_no` to 0 and turns off the drivers on the same edge. With the defaults, at least two states separate acceptance from acknowledge.
- R5: On the state just before the drivers turn off, every bit of `strb_no` is 1 and the drivers are still on.
- R6: While `back_no` is 0, `addr_oe_o`, `data_oe_o` and `strb_oe_o` are all 0 and `hold_cpu_o` is 1.
- R7: While released, `breq_ni` is sampled on every edge, whatever `sample_i` is. The first edge that sees it high raises `back_no` while the drivers stay off. The next edge turns the drivers back on and lowers `hold_cpu_o`.
- R8: `data_oe_o` is 1 only when the CPU owns the drivers and `data_drv_i` is 1.
- R9: `hold_cpu_o` rises on the edge that accepts the request and stays high until the drivers are restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus state clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| breq_ni | input | 1 | Bus request from the outside master, active low |
| sample_i | input | 1 | Marks the edges on which the request is sampled while the CPU owns the bus |
| cpu_busy_i | input | 1 | A CPU access is in flight |
| cpu_done_i | input | 1 | The current CPU access ends on this state |
| data_drv_i | input | 1 | The CPU wants to drive the data bus (write) |
| strb_ni | input | NSTRB | CPU strobes, active low (address strobe, read, upper and lower write) |
| back_no | output | 1 | Bus acknowledge, active low |
| hold_cpu_o | output | 1 | Stalls the sequencer from acceptance until the drivers are restored |
| addr_oe_o | output | 1 | Address driver enable |
| data_oe_o | output | 1 | Data driver enable |
| strb_oe_o | output | 1 | Strobe driver enable |
| strb_no | output | NSTRB | Strobes toward the pins, forced high around the handover |

## Verification
The bench sweeps the sample-point spacing against the length of the access in flight. For each pair it predicts the acknowledge edge from the second low sample and the end of the access. A controller that grants after one sample, or that does not wait for the access to end, drops acknowledge early. The bench sends a request pulse that is seen low at only one sample point, and a request that is low only between sample points. A design that accepts either of these stalls the CPU. It also checks that the strobes are high in the state before the drivers turn off, and that acknowledge is withdrawn one state before the drivers return. A design that skips the parking state shows active strobes at that point, and one that restores the drivers too early shows enables high while acknowledge is still low.

// File: rtl/bus_rel_pkg.sv
package bus_rel_pkg;
  typedef enum logic [2:0] {
    ST_OWN  = 3'd0,  // CPU owns the bus
    ST_PEND = 3'd1,  // request accepted, in-flight access finishing
    ST_PARK = 3'd2,  // strobes parked high, drivers still on
    ST_REL  = 3'd3,  // bus released to outside master
    ST_RETN = 3'd4   // ack withdrawn, drivers still off
  } rel_state_e;
endpackage

// File: rtl/bus_rel_filter.sv
module bus_rel_filter #(
  parameter int NUM_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic sample_i,
  input  logic breq_ni,
  output logic accept_o
);
  localparam int CW = $clog2(NUM_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(NUM_SAMPLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!enable_i)     cnt_q <= '0;
    else if (sample_i) begin
      if (breq_ni)          cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign accept_o = enable_i && sample_i && !breq_ni && (cnt_q == LAST);
endmodule

// File: rtl/bus_rel_fsm.sv
module bus_rel_fsm
  import bus_rel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       breq_ni,
  input  logic       cpu_busy_i,
  input  logic       cpu_done_i,
  output rel_state_e state_o
);
  rel_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN:  if (accept_i) state_d = ST_PEND;
      ST_PEND: if (!cpu_busy_i || cpu_done_i) state_d = ST_PARK;
      ST_PARK: state_d = ST_REL;
      ST_REL:  if (breq_ni) state_d = ST_RETN;
      ST_RETN: state_d = ST_OWN;
      default: state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OWN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_rel_gate.sv
module bus_rel_gate
  import bus_rel_pkg::*;
#(
  parameter int NSTRB = 4
) (
  input  rel_state_e       state_i,
  input  logic             data_drv_i,
  input  logic [NSTRB-1:0] strb_ni,
  output logic             back_no,
  output logic             hold_cpu_o,
  output logic             addr_oe_o,
  output logic             data_oe_o,
  output logic             strb_oe_o,
  output logic [NSTRB-1:0] strb_no
);
  logic owned, park;

  assign owned      = (state_i == ST_OWN) || (state_i == ST_PEND) || (state_i == ST_PARK);
  assign park       = !((state_i == ST_OWN) || (state_i == ST_PEND));
  assign back_no    = (state_i != ST_REL);
  assign hold_cpu_o = (state_i != ST_OWN);
  assign addr_oe_o  = owned;
  assign strb_oe_o  = owned;
  assign data_oe_o  = owned && data_drv_i;

  for (genvar i = 0; i < NSTRB; i++) begin : g_strb
    assign strb_no[i] = park ? 1'b1 : strb_ni[i];
  end
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl
  import bus_rel_pkg::*;
#(
  parameter int NUM_SAMPLES = 2,
  parameter int NSTRB       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             breq_ni,
  input  logic             sample_i,
  input  logic             cpu_busy_i,
  input  logic             cpu_done_i,
  input  logic             data_drv_i,
  input  logic [NSTRB-1:0] strb_ni,
  output logic             back_no,
  output logic             hold_cpu_o,
  output logic             addr_oe_o,
  output logic             data_oe_o,
  output logic             strb_oe_o,
  output logic [NSTRB-1:0] strb_no
);
  rel_state_e state;
  logic       accept;

  bus_rel_filter #(.NUM_SAMPLES(NUM_SAMPLES)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (state == ST_OWN),
    .sample_i (sample_i),
    .breq_ni  (breq_ni),
    .accept_o (accept)
  );

  bus_rel_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .breq_ni    (breq_ni),
    .cpu_busy_i (cpu_busy_i),
    .cpu_done_i (cpu_done_i),
    .state_o    (state)
  );

  bus_rel_gate #(.NSTRB(NSTRB)) u_gate (
    .state_i    (state),
    .data_drv_i (data_drv_i),
    .strb_ni    (strb_ni),
    .back_no    (back_no),
    .hold_cpu_o (hold_cpu_o),
    .addr_oe_o  (addr_oe_o),
    .data_oe_o  (data_oe_o),
    .strb_oe_o  (strb_oe_o),
    .strb_no    (strb_no)
  );
endmodule

// File: rtl/bus_rel_chk.sv
module bus_rel_chk #(
  parameter int NSTRB = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             breq_ni,
  input logic             data_drv_i,
  input logic             back_no,
  input logic             hold_cpu_o,
  input logic             addr_oe_o,
  input logic             data_oe_o,
  input logic             strb_oe_o,
  input logic [NSTRB-1:0] strb_no
);
  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !back_no |-> (!addr_oe_o && !data_oe_o && !strb_oe_o && hold_cpu_o));

  p_strb_park_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_oe_o) |-> $past(&strb_no));

  p_min_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(back_no) |-> ($past(hold_cpu_o) && $past(hold_cpu_o, 2)));

  p_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!back_no && breq_ni) |=> (back_no && !addr_oe_o));

  p_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> ($fell(hold_cpu_o) && $past(back_no)));

  p_data_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (data_drv_i && addr_oe_o));
endmodule

bind bus_release_ctrl bus_rel_chk #(.NSTRB(NSTRB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .breq_ni    (breq_ni),
  .data_drv_i (data_drv_i),
  .back_no    (back_no),
  .hold_cpu_o (hold_cpu_o),
  .addr_oe_o  (addr_oe_o),
  .data_oe_o  (data_oe_o),
  .strb_oe_o  (strb_oe_o),
  .strb_no    (strb_no)
);

// File: tb/bus_release_ctrl_test.sv
module bus_release_ctrl_test;
  localparam int NSTRB = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic breq_ni = 1'b1, sample_i = 1'b1, cpu_busy_i = 1'b0, cpu_done_i = 1'b0;
  logic data_drv_i = 1'b0;
  logic [NSTRB-1:0] strb_ni = '1;
  logic back_no, hold_cpu_o, addr_oe_o, data_oe_o, strb_oe_o;
  logic [NSTRB-1:0] strb_no;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_release_ctrl #(.NUM_SAMPLES(2), .NSTRB(NSTRB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .breq_ni(breq_ni), .sample_i(sample_i),
    .cpu_busy_i(cpu_busy_i), .cpu_done_i(cpu_done_i), .data_drv_i(data_drv_i),
    .strb_ni(strb_ni), .back_no(back_no), .hold_cpu_o(hold_cpu_o),
    .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o), .strb_oe_o(strb_oe_o),
    .strb_no(strb_no)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Request held low from edge 1; sample points every p edges; access ends at edge d.
  task automatic run_case(input int p, input int d);
    int a = 2 * p;
    int r = ((a + 1 > d) ? a + 1 : d) + 1;
    for (int k = 1; k <= r + 2; k++) begin
      breq_ni    = 1'b0;
      sample_i   = (k % p == 0);
      cpu_busy_i = (k <= d);
      cpu_done_i = (k == d);
      strb_ni    = (k <= d) ? '0 : '1;
      data_drv_i = 1'b1;
      step();
      chk($sformatf("R4 ack p=%0d d=%0d k=%0d", p, d, k), back_no, (k >= r) ? 0 : 1);
      chk("R6 addr_oe", addr_oe_o, (k >= r) ? 0 : 1);
      chk("R6 strb_oe", strb_oe_o, (k >= r) ? 0 : 1);
      chk("R9 hold", hold_cpu_o, (k >= a) ? 1 : 0);
      if (k == r - 1) chk("R5 strobes parked", strb_no, 4'hF);
      if (k >= r) chk("R8 data_oe released", data_oe_o, 0);
    end
    breq_ni = 1'b1; cpu_busy_i = 1'b0; cpu_done_i = 1'b0; strb_ni = '1;
    step();
    chk("R7 ack withdrawn", back_no, 1);
    chk("R7 drivers still off", addr_oe_o, 0);
    chk("R7 hold kept", hold_cpu_o, 1);
    step();
    chk("R7 drivers restored", addr_oe_o, 1);
    chk("R7 hold dropped", hold_cpu_o, 0);
    chk("R8 data_oe restored", data_oe_o, 1);
    data_drv_i = 1'b0;
    step();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 ack", back_no, 1);
    chk("R1 hold", hold_cpu_o, 0);
    chk("R1 addr_oe", addr_oe_o, 1);
    strb_ni = 4'h5;
    step();
    chk("R1 strobe pass", strb_no, 5);
    rst_ni = 1'b1;
    strb_ni = '1;
    step();
    chk("R1 after reset ack", back_no, 1);

    // R8 data enable follows write drive while owned
    data_drv_i = 1'b1; step();
    chk("R8 data_oe on", data_oe_o, 1);
    data_drv_i = 1'b0; step();
    chk("R8 data_oe off", data_oe_o, 0);

    // R3 single-sample pulse rejected
    sample_i = 1'b1;
    breq_ni = 1'b0; step();
    breq_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R3 pulse rejected hold", hold_cpu_o, 0);
      chk("R3 pulse rejected ack", back_no, 1);
    end

    // R2 low only between sample points is ignored; R3 non-consecutive lows rejected
    for (int k = 1; k <= 12; k++) begin
      sample_i = (k % 3 == 0);
      breq_ni  = (k % 3 == 0) ? ((k == 3 || k == 9) ? 1'b0 : 1'b1) : 1'b0;
      step();
      chk("R2 off-phase low ignored", hold_cpu_o, 0);
    end
    breq_ni = 1'b1; sample_i = 1'b1; step();

    // R4..R9 sweep over sample spacing and access length
    for (int p = 1; p <= 3; p++)
      for (int d = 0; d <= 9; d++)
        run_case(p, d);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule